// File: doc/BRIEF.md
# Programmable Four-Master Bus Arbiter

This block decides which of four bus masters owns a shared internal bus. Each master has a 2-bit priority that software sets in a 32-bit control word. The same word chooses between a strict priority scheme and a rotating scheme. It can turn on a starvation guard that forces access for a master that has waited 2^N cycles. It also sets where the grant rests when nobody requests. Master 2, the DMA engine, can jump to the top of the order through a bandwidth-control input, but only when this feature is enabled in the control word.

The grant is one-hot and always names exactly one master, so the bus is always parked on someone. The grant moves only in a cycle where `xfer_done` marks a transfer boundary. This means the current owner is never cut off partway through a transfer. Software writes the control word through a simple write strobe, and the stored value can be read back at any time.

Top module: `bus_arb4`

## Requirements
- R1: After reset the grant is 4'b1000 (master 3) and the control word reads 32'h00E1_0000. This value gives master 3 priority 3, master 2 priority 2, master 1 priority 1 and master 0 priority 0, and selects rotating mode with the starvation guard off and park-on-last.
- R2: Only bits 25:16 and 14:8 of the control word are stored. All other bits read as zero and ignore writes. Bit 24 is stored and read back but never changes a grant.
- R3: The priority fields sit at bits 23:22 (master 3), 21:20 (master 2), 19:18 (master 0) and 17:16 (master 1). The value 2'b11 is the highest level and 2'b00 the lowest. When bit 14 is 1 (fixed mode), the requesting master with the highest level wins.
- R4: If the four priority fields are not all different, the arbiter uses the order 3 > 2 > 1 > 0 instead.
- R5: When bit 14 is 0 (rotating mode), the current owner ranks below every other requester at a boundary. It keeps the bus only if no other master requests.
- R6: The grant changes only on the clock edge after a cycle with `xfer_done` high. With `xfer_done` low the grant holds whatever the requests do.
- R7: When bit 13 is 1, a master that has requested without being granted for 2^L consecutive cycles wins the next boundary ahead of all other rules. L is bits 11:8. If several masters expire at once, the lowest-numbered one wins.
- R8: When bit 13 is 0, no waiting time ever forces a grant.
- R9: When bit 25 is 1, `dma_boost` is high and master 2 requests, master 2 wins the boundary over every non-expired master. When bit 25 is 0, `dma_boost` has no effect.
- R10: With no requests and bit 12 = 0, the grant stays on the current owner.
- R11: With no requests and bit 12 = 1, the grant moves to the master with the highest effective priority.
- R12: The grant is always one-hot. After a boundary with at least one request, it names a master that was requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| cfg_rdata | output | 32 | Stored control word |
| req | input | 4 | Bus request, one bit per master |
| xfer_done | input | 1 | Transfer boundary: the grant may change on the next edge |
| dma_boost | input | 1 | Bandwidth-control request from the DMA master (master 2) |
| gnt | output | 4 | One-hot bus grant |

## Verification
All four masters requesting at once shows whether fixed mode and rotating mode differ: fixed mode keeps the bus on master 3, while rotating mode alternates it. Reduced request sets under a programmed permutation show that each field is decoded at its own bit position. A duplicated permutation shows whether the fallback order is used. Steady contention between two masters with a short lockout time tells the exact expiry cycle apart from an off-by-one, and the same contention with the guard off shows the guard is truly disabled. Idle cycles under each park setting, and the boost input with and without its enable bit or a master-2 request, tell the remaining rules apart.

// File: rtl/bus_arb4_pkg.sv
package bus_arb4_pkg;
    localparam int NM   = 4;
    localparam int PW   = 2;
    localparam int LTW  = 4;
    localparam int CNTW = (1 << LTW) + 1;
    localparam int DMA_ID = 2;

    localparam logic [31:0] CFG_RST   = 32'h00E1_0000;
    localparam logic [31:0] CFG_WMASK = 32'h03FF_7F00;

    typedef logic [NM-1:0]      mvec_t;
    typedef logic [NM*PW-1:0]   prio_t;

    typedef struct packed {
        logic           boost_en;
        logic           wide_cnt;
        logic [PW-1:0]  p3;
        logic [PW-1:0]  p2;
        logic [PW-1:0]  p0;
        logic [PW-1:0]  p1;
        logic           fixed;
        logic           to_en;
        logic           park_hi;
        logic [LTW-1:0] lock_exp;
    } cfg_t;

    function automatic cfg_t decode_cfg(logic [31:0] w);
        cfg_t c;
        c.boost_en = w[25];
        c.wide_cnt = w[24];
        c.p3       = w[23:22];
        c.p2       = w[21:20];
        c.p0       = w[19:18];
        c.p1       = w[17:16];
        c.fixed    = w[14];
        c.to_en    = w[13];
        c.park_hi  = w[12];
        c.lock_exp = w[11:8];
        return c;
    endfunction

    // Effective priority per master, falling back to 3>2>1>0 on duplicates.
    function automatic prio_t eff_prio(cfg_t c);
        prio_t p;
        mvec_t seen;
        p = {c.p3, c.p2, c.p1, c.p0};
        seen = '0;
        for (int i = 0; i < NM; i++) begin
            seen[p[i*PW +: PW]] = 1'b1;
        end
        if (seen != '1) begin
            for (int i = 0; i < NM; i++) begin
                p[i*PW +: PW] = PW'(i);
            end
        end
        return p;
    endfunction

    // One-hot of the highest-priority master within mask (priorities unique).
    function automatic mvec_t pick_top(mvec_t mask, prio_t p);
        mvec_t r;
        logic [PW-1:0] best;
        logic found;
        r = '0;
        best = '0;
        found = 1'b0;
        for (int i = 0; i < NM; i++) begin
            if (mask[i] && (!found || p[i*PW +: PW] > best)) begin
                r = '0;
                r[i] = 1'b1;
                best = p[i*PW +: PW];
                found = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic mvec_t lowest_set(mvec_t m);
        mvec_t r;
        r = '0;
        for (int i = NM - 1; i >= 0; i--) begin
            if (m[i]) begin
                r = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/bus_arb4_regs.sv
module bus_arb4_regs
    import bus_arb4_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output cfg_t        cfg
);
    logic [31:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= CFG_RST;
        end else if (we) begin
            word_q <= wdata & CFG_WMASK;
        end
    end

    assign rdata = word_q;
    assign cfg   = decode_cfg(word_q);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (rdata & ~CFG_WMASK) == 32'h0);
endmodule

// File: rtl/bus_arb4_starve.sv
module bus_arb4_starve
    import bus_arb4_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [LTW-1:0] lock_exp,
    input  mvec_t          req,
    input  mvec_t          gnt,
    output mvec_t          expired
);
    logic [CNTW-1:0] limit;
    assign limit = CNTW'(1) << lock_exp;

    for (genvar i = 0; i < NM; i++) begin : g_wait
        logic [CNTW-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst || !en || !req[i] || gnt[i]) begin
                cnt_q <= '0;
            end else if (cnt_q != '1) begin
                cnt_q <= cnt_q + CNTW'(1);
            end
        end
        assign expired[i] = en && req[i] && (cnt_q >= limit);
    end

    // R8
    no_expiry_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !(|expired) || $past(en) == en);
endmodule

// File: rtl/bus_arb4_pick.sv
module bus_arb4_pick
    import bus_arb4_pkg::*;
(
    input  prio_t prio,
    input  mvec_t req,
    input  mvec_t expired,
    input  mvec_t owner,
    input  logic  fixed,
    input  logic  boost,
    input  logic  park_hi,
    output mvec_t nxt
);
    mvec_t others;
    assign others = req & ~owner;

    always_comb begin
        if (|expired) begin
            nxt = lowest_set(expired);
        end else if (boost) begin
            nxt = '0;
            nxt[DMA_ID] = 1'b1;
        end else if (|req) begin
            if (fixed) begin
                nxt = pick_top(req, prio);
            end else if (|others) begin
                nxt = pick_top(others, prio);
            end else begin
                nxt = owner;
            end
        end else if (park_hi) begin
            nxt = pick_top('1, prio);
        end else begin
            nxt = owner;
        end
    end
endmodule

// File: rtl/bus_arb4.sv
module bus_arb4
    import bus_arb4_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [3:0]  req,
    input  logic        xfer_done,
    input  logic        dma_boost,
    output logic [3:0]  gnt
);
    cfg_t  cfg;
    prio_t prio;
    mvec_t expired;
    mvec_t nxt;
    mvec_t gnt_q;
    logic  boost;

    bus_arb4_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    assign prio  = eff_prio(cfg);
    assign boost = cfg.boost_en && dma_boost && req[DMA_ID];

    bus_arb4_starve u_starve (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg.to_en),
        .lock_exp (cfg.lock_exp),
        .req      (req),
        .gnt      (gnt_q),
        .expired  (expired)
    );

    bus_arb4_pick u_pick (
        .prio    (prio),
        .req     (req),
        .expired (expired),
        .owner   (gnt_q),
        .fixed   (cfg.fixed),
        .boost   (boost),
        .park_hi (cfg.park_hi),
        .nxt     (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q <= 4'b1000;
        end else if (xfer_done) begin
            gnt_q <= nxt;
        end
    end

    assign gnt = gnt_q;

    // R12
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(gnt_q) == 1);

    // R12
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && |req) |=> |(gnt_q & $past(req)));

    // R6
    hold_mid_transfer_chk: assert property (@(posedge clk) disable iff (rst)
        !xfer_done |=> $stable(gnt_q));

    // R7
    expired_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && expired[0]) |=> gnt_q[0]);

    // R9
    dma_boost_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !(|expired) && cfg.boost_en && dma_boost && req[DMA_ID])
        |=> gnt_q[DMA_ID]);

    // R10
    park_last_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && req == 4'b0000 && !cfg.park_hi) |=> $stable(gnt_q));
endmodule

// File: tb/tb_bus_arb4.sv
module tb_bus_arb4;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [3:0]  req = '0;
    logic        xfer_done = 1'b0;
    logic        dma_boost = 1'b0;
    logic [3:0]  gnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_arb4 dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .req       (req),
        .xfer_done (xfer_done),
        .dma_boost (dma_boost),
        .gnt       (gnt)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req = '0;
        xfer_done = 1'b0;
        dma_boost = 1'b0;
        cfg_we = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    task automatic write_cfg(logic [31:0] v);
        xfer_done = 1'b0;
        cfg_we = 1'b1;
        cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset grant", 32'(gnt), 32'h8);
        chk("R1 reset word", cfg_rdata, 32'h00E1_0000);
    endtask

    task automatic t_regs();
        do_reset();
        write_cfg(32'hFFFF_FFFF);
        chk("R2 writable mask", cfg_rdata, 32'h03FF_7F00);
        write_cfg(32'h0000_0000);
        chk("R2 clear", cfg_rdata, 32'h0);
        write_cfg(32'h01E1_4000);
        chk("R2 bit24 readback", cfg_rdata, 32'h01E1_4000);
        req = 4'b1111; xfer_done = 1'b1;
        tick();
        chk("R2 bit24 no effect", 32'(gnt), 32'h8);
    endtask

    task automatic t_prio();
        do_reset();
        write_cfg(32'h001E_4000);
        req = 4'b1111; xfer_done = 1'b1;
        tick();
        chk("R3 m0 top", 32'(gnt), 32'h1);
        req = 4'b1110;
        tick();
        chk("R3 m1 second", 32'(gnt), 32'h2);
        req = 4'b1100;
        tick();
        chk("R3 m2 third", 32'(gnt), 32'h4);
        write_cfg(32'h00FF_4000);
        req = 4'b1111; xfer_done = 1'b1;
        tick();
        chk("R4 dup fallback m3", 32'(gnt), 32'h8);
        req = 4'b0011;
        tick();
        chk("R4 dup fallback m1", 32'(gnt), 32'h2);
    endtask

    task automatic t_rr();
        do_reset();
        req = 4'b1111; xfer_done = 1'b1;
        tick();
        chk("R5 rr step1", 32'(gnt), 32'h4);
        tick();
        chk("R5 rr step2", 32'(gnt), 32'h8);
        tick();
        chk("R5 rr step3", 32'(gnt), 32'h4);
        req = 4'b0100;
        tick();
        chk("R5 rr sole owner keeps", 32'(gnt), 32'h4);
    endtask

    task automatic t_hold();
        do_reset();
        write_cfg(32'h00E1_4000);
        req = 4'b0001; xfer_done = 1'b1;
        tick();
        chk("R6 boundary grant", 32'(gnt), 32'h1);
        req = 4'b1000; xfer_done = 1'b0;
        repeat (3) tick();
        chk("R6 hold mid transfer", 32'(gnt), 32'h1);
        xfer_done = 1'b1;
        tick();
        chk("R6 move at boundary", 32'(gnt), 32'h8);
    endtask

    task automatic t_timeout();
        int hit;
        do_reset();
        write_cfg(32'h00E1_6200);
        req = 4'b1001; xfer_done = 1'b1;
        hit = 0;
        for (int n = 1; n <= 20; n++) begin
            tick();
            if (gnt[0] && hit == 0) hit = n;
        end
        chk("R7 expiry edge", 32'(hit), 32'd5);
        do_reset();
        write_cfg(32'h00E1_4200);
        req = 4'b1001; xfer_done = 1'b1;
        hit = 0;
        for (int n = 1; n <= 40; n++) begin
            tick();
            if (gnt[0]) hit = 1;
        end
        chk("R8 guard off never forces", 32'(hit), 32'd0);
        chk("R8 m3 keeps bus", 32'(gnt), 32'h8);
    endtask

    task automatic t_boost();
        do_reset();
        write_cfg(32'h02E1_4000);
        req = 4'b1111; dma_boost = 1'b1; xfer_done = 1'b1;
        tick();
        chk("R9 boost wins", 32'(gnt), 32'h4);
        dma_boost = 1'b0;
        tick();
        chk("R9 boost low", 32'(gnt), 32'h8);
        dma_boost = 1'b1; req = 4'b1011;
        tick();
        chk("R9 boost without m2 request", 32'(gnt), 32'h8);
        write_cfg(32'h00E1_4000);
        req = 4'b1111; dma_boost = 1'b1; xfer_done = 1'b1;
        tick();
        chk("R9 boost disabled ignored", 32'(gnt), 32'h8);
    endtask

    task automatic t_park();
        do_reset();
        req = 4'b0001; xfer_done = 1'b1;
        tick();
        chk("R10 setup m0", 32'(gnt), 32'h1);
        req = 4'b0000;
        tick();
        tick();
        chk("R10 park last", 32'(gnt), 32'h1);
        write_cfg(32'h00E1_1000);
        xfer_done = 1'b1;
        tick();
        chk("R11 park highest default", 32'(gnt), 32'h8);
        write_cfg(32'h001E_1000);
        xfer_done = 1'b1;
        tick();
        chk("R11 park highest programmed", 32'(gnt), 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_regs();
        t_prio();
        t_rr();
        t_hold();
        t_timeout();
        t_boost();
        t_park();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule